// File: doc/BRIEF.md
# Dual-Domain Reset Generator

This block produces two active-low resets for a small processor subsystem: one for the system domain and one for the debug logic. Both come from an asynchronous power-on reset input. The system reset can also be triggered by a reset request that the processor issues. A power-on event pulls both outputs low at once. A processor request pulls only the system reset low, so an attached debugger keeps its session across a software-initiated reset.

The request is registered before it can affect the system reset. It is then stretched into a pulse of `MIN_RST_CYCLES` clock cycles. The active system reset discards the captured request, so one request gives one pulse. Every release of either output happens on a rising edge of the system clock. After power-on, the debug reset is released first and the system reset one cycle later.

Top module: `dual_rst_gen`

## Requirements
- R1: While `rst_ni` is low, `sys_rst_no` and `dbg_rst_no` are both low, and they go low asynchronously, without waiting for a clock edge.
- R2: After `rst_ni` rises, `dbg_rst_no` goes high at the second rising clock edge and `sys_rst_no` at the third.
- R3: The request reaches the system reset only through registers. A request that is high at a rising edge pulls `sys_rst_no` low at the following rising edge, and never earlier.
- R4: A request pulse holds `sys_rst_no` low for exactly `MIN_RST_CYCLES` clock cycles (default 4, minimum 2).
- R5: `dbg_rst_no` never goes low because of a request. Only `rst_ni` can pull it low.
- R6: Whenever `dbg_rst_no` is low, `sys_rst_no` is also low. `sys_rst_no` is never released before `dbg_rst_no`.
- R7: Each assertion of either output lasts at least two clock cycles.
- R8: Every low-to-high transition of either output happens on a rising edge of `clk_i`.
- R9: A request that arrives while `sys_rst_no` is low, whether during power-on or during a request pulse, is discarded. It neither extends the pulse nor starts a second one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| sys_req_i | input | 1 | System reset request from the processor, active high |
| sys_rst_no | output | 1 | System-domain reset, active low |
| dbg_rst_no | output | 1 | Debug-domain reset, active low |

## Verification
The bench measures the exact length of each request pulse and the cycle in which it starts. A design that passed the request straight through combinationally would go low one cycle early. A design with an off-by-one counter would give a pulse one cycle too long or too short.

It raises a second request in the middle of a pulse and holds a request high through power-on. A design that did not discard these would stretch the pulse or fire a spurious second reset.

It asserts power-on reset halfway between clock edges in the middle of a pulse, and it times every rising edge of both outputs against the clock. This catches a design that waits for a clock edge to assert reset or that releases reset asynchronously.

Throughout, it watches the debug reset during request pulses. A design that routed the request into the debug domain would drop the debugger's reset there.

// File: rtl/dual_rst_pkg.sv
`timescale 1ns/1ps
package dual_rst_pkg;
  localparam int unsigned DEF_MIN_RST_CYCLES = 4;
  localparam int unsigned DEF_SYNC_STAGES    = 2;
endpackage

// File: rtl/rst_sync_chain.sv
`timescale 1ns/1ps
// Asynchronous assert, synchronous release.
module rst_sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[i] <= 1'b0;
      else if (i == 0) stage_q[i] <= 1'b1;
      else stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
    end
  end

  assign rst_no = stage_q[STAGES-1];
endmodule

// File: rtl/req_stretch.sv
`timescale 1ns/1ps
// Registers the request and stretches it into a fixed-length low pulse.
module req_stretch #(
  parameter int unsigned MIN_RST_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic enable_i,
  output logic sys_rst_no
);
  localparam int unsigned CNT_W = $clog2(MIN_RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(MIN_RST_CYCLES - 1);

  logic             req_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sys_q;
  logic             low_d;

  assign low_d = req_q | (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      cnt_q <= '0;
      sys_q <= 1'b0;
    end else begin
      // capture only when reset is inactive; an active reset drops it
      req_q <= req_i & sys_q & ~low_d;
      if (req_q)              cnt_q <= LOAD_VAL;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      sys_q <= enable_i & ~low_d;
    end
  end

  assign sys_rst_no = sys_q;
endmodule

// File: rtl/dual_rst_gen.sv
`timescale 1ns/1ps
module dual_rst_gen
  import dual_rst_pkg::*;
#(
  parameter int unsigned MIN_RST_CYCLES = DEF_MIN_RST_CYCLES,
  parameter int unsigned SYNC_STAGES    = DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_req_i,
  output logic sys_rst_no,
  output logic dbg_rst_no
);
  logic dbg_rst_n;

  rst_sync_chain #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (dbg_rst_n)
  );

  req_stretch #(.MIN_RST_CYCLES(MIN_RST_CYCLES)) u_stretch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (sys_req_i),
    .enable_i   (dbg_rst_n),
    .sys_rst_no (sys_rst_no)
  );

  assign dbg_rst_no = dbg_rst_n;
endmodule

// File: rtl/dual_rst_gen_chk.sv
`timescale 1ns/1ps
module dual_rst_gen_chk #(
  parameter int unsigned MIN_RST_CYCLES = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sys_req_i,
  input logic sys_rst_no,
  input logic dbg_rst_no
);
  logic [7:0] sys_run_q, dbg_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_run_q <= '0;
      dbg_run_q <= '0;
    end else begin
      sys_run_q <= sys_rst_no ? 8'd0 : sys_run_q + {7'd0, sys_run_q != 8'hff};
      dbg_run_q <= dbg_rst_no ? 8'd0 : dbg_run_q + {7'd0, dbg_run_q != 8'hff};
    end
  end

  // R6
  dbg_implies_sys_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbg_rst_no |-> !sys_rst_no);

  // R6
  release_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no) |-> dbg_rst_no);

  // R5
  dbg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_rst_no |=> dbg_rst_no);

  // R3
  registered_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_no) |-> $past(sys_req_i, 2));

  // R7
  sys_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no) |-> sys_run_q >= 8'd2);

  // R7
  dbg_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dbg_rst_no) |-> dbg_run_q >= 8'd2);
endmodule

bind dual_rst_gen dual_rst_gen_chk #(.MIN_RST_CYCLES(MIN_RST_CYCLES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sys_req_i  (sys_req_i),
  .sys_rst_no (sys_rst_no),
  .dbg_rst_no (dbg_rst_no)
);

// File: tb/sim_dual_rst_gen.sv
`timescale 1ns/1ps
module sim_dual_rst_gen;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_CYC    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic sys_rst_n, dbg_rst_n;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_rst_gen #(.MIN_RST_CYCLES(MIN_CYC)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sys_req_i  (req),
    .sys_rst_no (sys_rst_n),
    .dbg_rst_no (dbg_rst_n)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // R8: releases land on rising clock edges
  always @(posedge sys_rst_n) if (!done) chk("R8", "sys release phase", int'($time % CLK_PERIOD), CLK_PERIOD/2);
  always @(posedge dbg_rst_n) if (!done) chk("R8", "dbg release phase", int'($time % CLK_PERIOD), CLK_PERIOD/2);

  task automatic por_release();
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "dbg after 1 edge", dbg_rst_n, 0);
    chk("R2", "sys after 1 edge", sys_rst_n, 0);
    @(negedge clk);
    chk("R2", "dbg after 2 edges", dbg_rst_n, 1);
    chk("R6", "sys held after dbg release", sys_rst_n, 0);
    @(negedge clk);
    chk("R2", "sys after 3 edges", sys_rst_n, 1);
  endtask

  // starts at a negedge with sys high; returns at a negedge with sys high again
  task automatic run_pulse(input int mid_at, output int first, output int width, output int dbg_lo);
    req = 1'b1;
    #1;
    chk("R3", "no combinational path", sys_rst_n, 1);
    first = -1; width = 0; dbg_lo = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (!dbg_rst_n) dbg_lo++;
      if (!sys_rst_n) begin
        if (first < 0) first = i;
        width++;
      end else if (first >= 0) begin
        req = 1'b0;
        break;
      end
      req = (mid_at > 0) && !sys_rst_n && (width == mid_at);
    end
    req = 1'b0;
  endtask

  task automatic quiet_window(input string rq, input int n);
    int lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!sys_rst_n) lows++;
    end
    chk(rq, "no extra pulse", lows, 0);
  endtask

  task automatic t_power_on();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "dbg in por", dbg_rst_n, 0);
    chk("R1", "sys in por", sys_rst_n, 0);
    por_release();
  endtask

  task automatic t_single_req();
    int f, w, d;
    run_pulse(0, f, w, d);
    chk("R3", "first low negedge", f, 2);
    chk("R4", "pulse width", w, MIN_CYC);
    chk("R5", "dbg lows during pulse", d, 0);
    quiet_window("R9", 8);
  endtask

  task automatic t_req_in_pulse();
    int f, w, d;
    run_pulse(2, f, w, d);
    chk("R9", "pulse width with mid request", w, MIN_CYC);
    chk("R5", "dbg lows", d, 0);
    quiet_window("R9", 10);
  endtask

  task automatic t_back_to_back();
    int f, w, d;
    for (int k = 0; k < 2; k++) begin
      run_pulse(0, f, w, d);
      chk("R4", "repeated pulse width", w, MIN_CYC);
      chk("R7", "width at least two", int'(w >= 2), 1);
    end
  endtask

  task automatic t_req_during_por();
    @(negedge clk); rst_n = 1'b0; req = 1'b1;
    repeat (2) @(negedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R2", "dbg released", dbg_rst_n, 1);
    req = 1'b0;
    @(negedge clk);
    chk("R9", "sys released despite request", sys_rst_n, 1);
    quiet_window("R9", 8);
  endtask

  task automatic t_por_mid_pulse();
    req = 1'b1;
    @(negedge clk); req = 1'b0;
    @(negedge clk);
    chk("R4", "pulse started", sys_rst_n, 0);
    #2 rst_n = 1'b0;
    #1;
    chk("R1", "async dbg assert", dbg_rst_n, 0);
    chk("R1", "async sys assert", sys_rst_n, 0);
    repeat (2) @(negedge clk);
    por_release();
    quiet_window("R9", 6);
  endtask

  initial begin
    t_power_on();
    t_single_req();
    t_req_in_pulse();
    t_back_to_back();
    t_req_during_por();
    t_por_mid_pulse();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule